// File: doc/BRIEF.md
# Multi-Pipe Interrupt Aggregator

This block gathers interrupt requests from a group of DMA pipes and from four chip-wide event conditions, and turns them into one level interrupt line for each execution environment. Each pipe engine presents a level pending flag. The global conditions arrive as single-cycle event pulses. These pulses are latched into a sticky status register. A per-environment mask decides which sources reach that environment's interrupt line.

Software reaches the block through a simple single-cycle register port. A summary source register packs one bit per pipe together with a global bit at position 31. Every environment sees the same summary word through its own window, and each window has its own mask register. Handler code reads the summary word to learn which sources are pending. It then services the pipes and clears the global status bits by writing ones. The interrupt line drops as soon as nothing unmasked remains pending. Read-only words report the revision, the environment count and the pipe count, so driver code can size itself.

Top module: `pipe_irq_aggregator`

## Requirements
- R1: After reset, the global status, global enable and all environment masks are zero, every `irq_o` bit is low, and `reg_rdata_o` is zero.
- R2: A read of offset 0x04 returns NUM_EE in bits 11:8, REVISION in bits 7:0 and zero elsewhere. A read of offset 0x3C returns NUM_PIPES in bits 7:0 and zero elsewhere.
- R3: A pulse on `glb_evt_i[k]` sets global status bit k+1. Index 0 is the bus response error, 1 the error, 2 the empty condition and 3 the timer. The bit stays set until it is cleared, and the status reads at offset 0x14 in bits 4:1.
- R4: Writing to offset 0x18 clears every global status bit whose bit in the written data (bits 4:1) is one. An event arriving in the same cycle as its clear leaves the bit set. Offset 0x18 reads as zero.
- R5: Offset 0x1C holds the global enable bits 4:1, with the same layout as the status. They are written and read back, and the other bits read zero.
- R6: The source register of environment `e` sits at offset 0x800 + e*0x80. Its bits NUM_PIPES-1:0 show `pipe_pend_i` as sampled in the access cycle. Bits 30:NUM_PIPES read zero. Bit 31 is one when any global status bit is set together with its enable bit.
- R7: The mask register of environment `e` sits at 4 bytes above its source register. It stores the implemented bits, which are bit 31 and bits NUM_PIPES-1:0, and it reads the other bits as zero. Each environment's mask is independent of the others.
- R8: `irq_o[e]` is high while (source AND mask of environment e) is nonzero. It follows `pipe_pend_i` in the same cycle, and it follows register writes from the clock edge that performs them.
- R9: An access to an environment index at or above NUM_EE reads zero and its writes change no state. Any offset not listed above also reads zero.
- R10: Read data appears on `reg_rdata_o` in the cycle after the read access. In every cycle that does not follow a read, `reg_rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Access is a write when high |
| reg_addr_i | input | 16 | Byte offset of the access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, registered |
| pipe_pend_i | input | NUM_PIPES | Per-pipe pending interrupt levels |
| glb_evt_i | input | 4 | Global event pulses (bus error, error, empty, timer) |
| irq_o | output | NUM_EE | Level-high interrupt, one per environment |

## Verification
A corrupted status or enable bit appears in bit 31 of every source window, and on the line of every environment that unmasks it, from the edge right after the fault. A corrupted mask bit appears only on its own environment's line, and only while the matching source is pending. For that reason the stimulus holds pipes pending across mask writes and reads the masks back. A wrong read-path select appears on `reg_rdata_o` one cycle after the access, and a stale value appears in the idle cycle that follows, where zero is expected.

// File: rtl/pia_pkg.sv
package pia_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 16;
    localparam int EVT_W   = 4;
    localparam int IDX_W   = 4;

    localparam logic [ADDR_W-1:0] OFS_CAP   = 16'h0004;
    localparam logic [ADDR_W-1:0] OFS_GSTAT = 16'h0014;
    localparam logic [ADDR_W-1:0] OFS_GCLR  = 16'h0018;
    localparam logic [ADDR_W-1:0] OFS_GEN   = 16'h001C;
    localparam logic [ADDR_W-1:0] OFS_PCNT  = 16'h003C;

    localparam logic [4:0] EE_REGION = 5'b00001;
    localparam logic [6:0] EE_SRC    = 7'h00;
    localparam logic [6:0] EE_MSK    = 7'h04;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CAP,
        SEL_PCNT,
        SEL_GSTAT,
        SEL_GEN,
        SEL_SRC,
        SEL_MASK
    } rd_sel_e;

    function automatic logic [DATA_W-1:0] impl_mask(input int np);
        logic [DATA_W-1:0] m;
        m = '0;
        m[DATA_W-1] = 1'b1;
        for (int i = 0; i < np; i++) begin
            m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pia_glb_stat.sv
module pia_glb_stat
    import pia_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [EVT_W-1:0] evt_i,
    input  logic             clr_we_i,
    input  logic             ena_we_i,
    input  logic [EVT_W-1:0] wbits_i,
    output logic [EVT_W-1:0] stat_o,
    output logic [EVT_W-1:0] ena_o,
    output logic             pend_o
);

    typedef struct packed {
        logic [EVT_W-1:0] stat;
        logic [EVT_W-1:0] ena;
    } glb_state_t;

    glb_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_we_i) begin
            s_d.stat = s_q.stat & ~wbits_i;
        end
        s_d.stat = s_d.stat | evt_i;
        if (ena_we_i) begin
            s_d.ena = wbits_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stat_o = s_q.stat;
    assign ena_o  = s_q.ena;
    assign pend_o = |(s_q.stat & s_q.ena);

endmodule

// File: rtl/pia_ee_bank.sv
module pia_ee_bank
    import pia_pkg::*;
#(
    parameter int NUM_PIPES = 8,
    parameter int NUM_EE    = 4
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           wr_i,
    input  logic [IDX_W-1:0]               sel_i,
    input  logic [DATA_W-1:0]              wdata_i,
    input  logic [DATA_W-1:0]              src_i,
    output logic [NUM_EE-1:0][DATA_W-1:0]  mask_o,
    output logic [NUM_EE-1:0]              irq_o
);

    localparam logic [DATA_W-1:0] IMPL = impl_mask(NUM_PIPES);

    for (genvar e = 0; e < NUM_EE; e++) begin : g_ee
        typedef struct packed {
            logic [DATA_W-1:0] mask;
        } ee_state_t;

        ee_state_t m_d, m_q;

        always_comb begin
            m_d = m_q;
            if (wr_i && (sel_i == IDX_W'(e))) begin
                m_d.mask = wdata_i & IMPL;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                m_q <= '0;
            end else begin
                m_q <= m_d;
            end
        end

        assign mask_o[e] = m_q.mask;
        assign irq_o[e]  = |(src_i & m_q.mask);
    end

endmodule

// File: rtl/pia_rd_mux.sv
module pia_rd_mux
    import pia_pkg::*;
#(
    parameter int NUM_EE = 4
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          rd_i,
    input  rd_sel_e                       sel_i,
    input  logic [IDX_W-1:0]              idx_i,
    input  logic [DATA_W-1:0]             cap_i,
    input  logic [DATA_W-1:0]             pcnt_i,
    input  logic [EVT_W-1:0]              stat_i,
    input  logic [EVT_W-1:0]              ena_i,
    input  logic [DATA_W-1:0]             src_i,
    input  logic [NUM_EE-1:0][DATA_W-1:0] mask_i,
    output logic [DATA_W-1:0]             rdata_o
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t r_d, r_q;
    logic [DATA_W-1:0] msel;

    always_comb begin
        msel = '0;
        for (int e = 0; e < NUM_EE; e++) begin
            if (idx_i == IDX_W'(e)) begin
                msel = mask_i[e];
            end
        end
    end

    always_comb begin
        r_d.rdata = '0;
        if (rd_i) begin
            unique case (sel_i)
                SEL_CAP:   r_d.rdata = cap_i;
                SEL_PCNT:  r_d.rdata = pcnt_i;
                SEL_GSTAT: r_d.rdata = {27'b0, stat_i, 1'b0};
                SEL_GEN:   r_d.rdata = {27'b0, ena_i, 1'b0};
                SEL_SRC:   r_d.rdata = src_i;
                SEL_MASK:  r_d.rdata = msel;
                default:   r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata_o = r_q.rdata;

endmodule

// File: rtl/pipe_irq_aggregator.sv
module pipe_irq_aggregator
    import pia_pkg::*;
#(
    parameter int          NUM_PIPES = 8,
    parameter int          NUM_EE    = 4,
    parameter logic [7:0]  REVISION  = 8'h13
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 reg_en_i,
    input  logic                 reg_we_i,
    input  logic [15:0]          reg_addr_i,
    input  logic [31:0]          reg_wdata_i,
    output logic [31:0]          reg_rdata_o,
    input  logic [NUM_PIPES-1:0] pipe_pend_i,
    input  logic [3:0]           glb_evt_i,
    output logic [NUM_EE-1:0]    irq_o
);

    localparam logic [DATA_W-1:0] CAP_WORD  = {20'b0, 4'(NUM_EE), REVISION};
    localparam logic [DATA_W-1:0] PCNT_WORD = DATA_W'(NUM_PIPES);

    logic                          rd_acc, wr_acc;
    logic                          ee_win, ee_ok;
    logic [IDX_W-1:0]              ee_idx;
    rd_sel_e                       rd_sel;
    logic                          gclr_we, gen_we, msk_we;
    logic [EVT_W-1:0]              glb_stat, glb_ena;
    logic                          glb_pend;
    logic [DATA_W-1:0]             src_word;
    logic [NUM_EE-1:0][DATA_W-1:0] masks;

    assign rd_acc = reg_en_i && !reg_we_i;
    assign wr_acc = reg_en_i && reg_we_i;
    assign ee_idx = reg_addr_i[10:7];
    assign ee_win = (reg_addr_i[15:11] == EE_REGION);
    assign ee_ok  = ee_win && (int'(ee_idx) < NUM_EE);

    always_comb begin
        rd_sel = SEL_NONE;
        if (ee_ok && reg_addr_i[6:0] == EE_SRC) begin
            rd_sel = SEL_SRC;
        end else if (ee_ok && reg_addr_i[6:0] == EE_MSK) begin
            rd_sel = SEL_MASK;
        end else if (reg_addr_i == OFS_CAP) begin
            rd_sel = SEL_CAP;
        end else if (reg_addr_i == OFS_PCNT) begin
            rd_sel = SEL_PCNT;
        end else if (reg_addr_i == OFS_GSTAT) begin
            rd_sel = SEL_GSTAT;
        end else if (reg_addr_i == OFS_GEN) begin
            rd_sel = SEL_GEN;
        end
    end

    assign gclr_we = wr_acc && (reg_addr_i == OFS_GCLR);
    assign gen_we  = wr_acc && (rd_sel == SEL_GEN);
    assign msk_we  = wr_acc && (rd_sel == SEL_MASK);

    always_comb begin
        src_word = '0;
        src_word[NUM_PIPES-1:0] = pipe_pend_i;
        src_word[DATA_W-1] = glb_pend;
    end

    pia_glb_stat u_glb (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .evt_i    (glb_evt_i),
        .clr_we_i (gclr_we),
        .ena_we_i (gen_we),
        .wbits_i  (reg_wdata_i[4:1]),
        .stat_o   (glb_stat),
        .ena_o    (glb_ena),
        .pend_o   (glb_pend)
    );

    pia_ee_bank #(
        .NUM_PIPES (NUM_PIPES),
        .NUM_EE    (NUM_EE)
    ) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (msk_we),
        .sel_i   (ee_idx),
        .wdata_i (reg_wdata_i),
        .src_i   (src_word),
        .mask_o  (masks),
        .irq_o   (irq_o)
    );

    pia_rd_mux #(
        .NUM_EE (NUM_EE)
    ) u_rd (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rd_i    (rd_acc),
        .sel_i   (rd_sel),
        .idx_i   (ee_idx),
        .cap_i   (CAP_WORD),
        .pcnt_i  (PCNT_WORD),
        .stat_i  (glb_stat),
        .ena_i   (glb_ena),
        .src_i   (src_word),
        .mask_i  (masks),
        .rdata_o (reg_rdata_o)
    );

endmodule

// File: rtl/pia_checker.sv
module pia_checker #(
    parameter int NUM_EE = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              reg_en_i,
    input logic              reg_we_i,
    input logic [15:0]       reg_addr_i,
    input logic [31:0]       reg_wdata_i,
    input logic [31:0]       reg_rdata_o,
    input logic [3:0]        glb_evt_i,
    input logic [3:0]        gstat,
    input logic [NUM_EE-1:0] irq_o
);

    AST_EVT_SETS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (glb_evt_i != 4'b0) |=> ((gstat & $past(glb_evt_i)) == $past(glb_evt_i))); // R3

    AST_CLEAR_ALL_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_en_i && reg_we_i && reg_addr_i == 16'h0018 && reg_wdata_i[4:1] == 4'hF
         && glb_evt_i == 4'b0) |=> (gstat == 4'b0)); // R4

    AST_MASK_ZERO_QUIETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_en_i && reg_we_i && reg_addr_i == 16'h0804 && reg_wdata_i == 32'h0)
        |=> !irq_o[0]); // R8

    AST_OUT_OF_RANGE_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_en_i && !reg_we_i && reg_addr_i[15:11] == 5'b00001
         && int'(reg_addr_i[10:7]) >= NUM_EE) |=> (reg_rdata_o == 32'h0)); // R9

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(reg_en_i && !reg_we_i) |=> (reg_rdata_o == 32'h0)); // R10

    AST_CAP_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_en_i && !reg_we_i && reg_addr_i == 16'h0004)
        |=> (reg_rdata_o[31:12] == 20'h0)); // R2

endmodule

bind pipe_irq_aggregator pia_checker #(
    .NUM_EE (NUM_EE)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_en_i    (reg_en_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .glb_evt_i   (glb_evt_i),
    .gstat       (glb_stat),
    .irq_o       (irq_o)
);

// File: tb/pipe_irq_aggregator_tb_top.sv
module pipe_irq_aggregator_tb_top;

    localparam int NP  = 8;
    localparam int NEE = 4;

    typedef struct packed {
        logic        en;
        logic        we;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic [7:0]  pend;
        logic [3:0]  evt;
        logic [31:0] exp_rd;
        logic [3:0]  exp_irq;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 16'h0004, 32'h0,         8'h00, 4'h0, 32'h0000_0413, 4'b0000, 8'd2},  // R2 capability
        '{1'b1, 1'b0, 16'h003C, 32'h0,         8'h00, 4'h0, 32'h0000_0008, 4'b0000, 8'd2},  // R2 pipe count
        '{1'b1, 1'b1, 16'h0804, 32'hFFFF_FFFF, 8'h00, 4'h0, 32'h0,         4'b0000, 8'd7},  // R7 write ee0 mask
        '{1'b1, 1'b0, 16'h0804, 32'h0,         8'h00, 4'h0, 32'h8000_00FF, 4'b0000, 8'd7},  // R7 implemented bits
        '{1'b1, 1'b0, 16'h0800, 32'h0,         8'h05, 4'h0, 32'h0000_0005, 4'b0001, 8'd6},  // R6 pipe bits, R8
        '{1'b1, 1'b1, 16'h0884, 32'h0000_0004, 8'h05, 4'h0, 32'h0,         4'b0011, 8'd8},  // R8 ee1 unmasked
        '{1'b1, 1'b0, 16'h0884, 32'h0,         8'h01, 4'h0, 32'h0000_0004, 4'b0001, 8'd8},  // R8 follows pend
        '{1'b0, 1'b0, 16'h0000, 32'h0,         8'h00, 4'b0100, 32'h0,      4'b0000, 8'd3},  // R3 empty event
        '{1'b1, 1'b0, 16'h0014, 32'h0,         8'h00, 4'h0, 32'h0000_0008, 4'b0000, 8'd3},  // R3 status read
        '{1'b1, 1'b1, 16'h001C, 32'hFFFF_FFFF, 8'h00, 4'h0, 32'h0,         4'b0001, 8'd5},  // R5 enable
        '{1'b1, 1'b0, 16'h001C, 32'h0,         8'h00, 4'h0, 32'h0000_001E, 4'b0001, 8'd5},  // R5 readback
        '{1'b1, 1'b0, 16'h0800, 32'h0,         8'h00, 4'h0, 32'h8000_0000, 4'b0001, 8'd6},  // R6 global bit
        '{1'b1, 1'b1, 16'h0904, 32'h8000_0000, 8'h00, 4'h0, 32'h0,         4'b0101, 8'd7},  // R7 ee2 mask
        '{1'b1, 1'b1, 16'h0018, 32'h0000_0008, 8'h00, 4'b0001, 32'h0,      4'b0101, 8'd4},  // R4 clear + new event
        '{1'b1, 1'b0, 16'h0014, 32'h0,         8'h00, 4'h0, 32'h0000_0002, 4'b0101, 8'd4},  // R4 result
        '{1'b1, 1'b1, 16'h0018, 32'h0000_0002, 8'h00, 4'h0, 32'h0,         4'b0000, 8'd4},  // R4 last clear
        '{1'b1, 1'b0, 16'h0018, 32'h0,         8'h00, 4'h0, 32'h0,         4'b0000, 8'd4},  // R4 clear reads zero
        '{1'b1, 1'b1, 16'h0A04, 32'hFFFF_FFFF, 8'h00, 4'h0, 32'h0,         4'b0000, 8'd9},  // R9 write ignored
        '{1'b1, 1'b0, 16'h0A04, 32'h0,         8'hFF, 4'h0, 32'h0,         4'b0011, 8'd9},  // R9 reads zero
        '{1'b1, 1'b0, 16'h0A00, 32'h0,         8'hFF, 4'h0, 32'h0,         4'b0011, 8'd9},  // R9 source zero
        '{1'b1, 1'b0, 16'h0040, 32'h0,         8'h00, 4'h0, 32'h0,         4'b0000, 8'd9},  // R9 unmapped
        '{1'b1, 1'b1, 16'h001C, 32'h0,         8'h00, 4'h0, 32'h0,         4'b0000, 8'd5},  // R5 disable
        '{1'b1, 1'b1, 16'h0018, 32'h0000_0010, 8'h00, 4'b1000, 32'h0,      4'b0000, 8'd4},  // R4 event wins
        '{1'b1, 1'b0, 16'h0014, 32'h0,         8'h00, 4'h0, 32'h0000_0010, 4'b0000, 8'd4},  // R4 timer kept
        '{1'b1, 1'b1, 16'h001C, 32'h0000_0010, 8'h00, 4'h0, 32'h0,         4'b0101, 8'd8},  // R8 via enable
        '{1'b1, 1'b1, 16'h0804, 32'h0,         8'h00, 4'h0, 32'h0,         4'b0100, 8'd8},  // R8 mask off ee0
        '{1'b1, 1'b0, 16'h0804, 32'h0,         8'h00, 4'h0, 32'h0,         4'b0100, 8'd7},  // R7 readback
        '{1'b1, 1'b0, 16'h0904, 32'h0,         8'h00, 4'h0, 32'h8000_0000, 4'b0100, 8'd7}   // R7 independent
    };

    logic          clk;
    logic          rst_n;
    logic          reg_en;
    logic          reg_we;
    logic [15:0]   reg_addr;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] pipe_pend;
    logic [3:0]    glb_evt;
    logic [NEE-1:0] irq;

    int n_tests = 0;
    int n_fail  = 0;

    initial clk = 1'b0;
    always #2 clk = ~clk;

    pipe_irq_aggregator #(
        .NUM_PIPES (NP),
        .NUM_EE    (NEE),
        .REVISION  (8'h13)
    ) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_en_i    (reg_en),
        .reg_we_i    (reg_we),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .pipe_pend_i (pipe_pend),
        .glb_evt_i   (glb_evt),
        .irq_o       (irq)
    );

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive_idle();
        reg_en    = 1'b0;
        reg_we    = 1'b0;
        reg_addr  = 16'h0;
        reg_wdata = 32'h0;
        glb_evt   = 4'h0;
    endtask

    task automatic do_read(input logic [15:0] a);
        reg_en   = 1'b1;
        reg_we   = 1'b0;
        reg_addr = a;
        @(negedge clk);
        drive_idle();
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        drive_idle();
        pipe_pend = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(1, "rdata after reset", reg_rdata, 32'h0);
        check(1, "irq after reset", {28'h0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            reg_en    = VECS[i].en;
            reg_we    = VECS[i].we;
            reg_addr  = VECS[i].addr;
            reg_wdata = VECS[i].wdata;
            pipe_pend = VECS[i].pend;
            glb_evt   = VECS[i].evt;
            @(negedge clk);
            // R10: rdata is the read value or zero after non-reads
            check(int'(VECS[i].req), $sformatf("vec %0d rdata", i), reg_rdata, VECS[i].exp_rd);
            check(int'(VECS[i].req), $sformatf("vec %0d irq", i), {28'h0, irq}, {28'h0, VECS[i].exp_irq});
            drive_idle();
        end

        // R10: rdata returns to zero the cycle after a read
        do_read(16'h0004);
        check(10, "rdata of read", reg_rdata, 32'h0000_0413);
        @(negedge clk);
        check(10, "rdata idle", reg_rdata, 32'h0);

        // R1: reset mid-run clears state
        pipe_pend = 8'hFF;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, "irq after reset, pipes pending", {28'h0, irq}, 32'h0);
        do_read(16'h001C);
        check(1, "enable after reset", reg_rdata, 32'h0);
        do_read(16'h0014);
        check(1, "status after reset", reg_rdata, 32'h0);
        do_read(16'h0904);
        check(1, "ee2 mask after reset", reg_rdata, 32'h0);
        do_read(16'h0980);
        check(6, "ee3 source, pipes all pending", reg_rdata, 32'h0000_00FF);

        finish_run();
    end

endmodule